// File: doc/BRIEF.md
# Chip-Select Gated Duplicating Register

This block is a bank of 28 single-bit registers that sits in the command and address path of a memory module. On every rising clock edge each input bit is captured, and every registered bit drives two output copies, A and B, which always carry the same value. That way one captured command word can feed two groups of memory loads.

To save power the ordinary address and command outputs can be frozen. When the gate-enable input is high and both chip-select bits arriving at the edge are high, no memory device is being addressed, so the ordinary outputs keep their previous value. The six control bits (two clock enables, two chip selects, two termination controls) still update on every edge. A static map-select input chooses which input positions carry those six control bits. An active-low asynchronous reset clears every output at once, whatever the gating state.

The clock is a single-ended rising edge. Inputs are numbered 1 to 28, and input n is bit n-1 of `d_in`, `q_a` and `q_b`.

Top module: `csgate_dup_reg`

## Requirements
- R1: There are 28 data inputs, and each registered bit drives `q_a` and `q_b`, which are equal at all times.
- R2: With `map_sel` = 0 the control bits sit on the following inputs. Clock enables are on inputs 8 (CKE0) and 6 (CKE1), which are bits 7 and 5. Chip selects are on inputs 14 (CS0) and 13 (CS1), which are bits 13 and 12. Termination controls are on inputs 15 and 16, which are bits 14 and 15.
- R3: With `map_sel` = 1 the control bits move. Termination controls are on inputs 14 and 13, which are bits 13 and 12. Chip selects are on inputs 15 (CS0) and 16 (CS1), which are bits 14 and 15. Clock enables are on inputs 21 and 23, which are bits 20 and 22.
- R4: At a rising edge where `gate_en` = 1 and both chip-select inputs of the active map are 1, every ordinary (non-control) output bit keeps its previous value.
- R5: At a rising edge where `gate_en` = 0, or either chip-select input is 0, every output bit loads its input.
- R6: The six control output bits of the active map load their inputs on every rising edge, whatever the gating state.
- R7: Driving `rst_n` low forces all of `q_a` and `q_b` to 0 at once, without waiting for a clock edge. This takes priority over gating.
- R8: After `rst_n` rises, the outputs stay 0 until the first rising edge, which then captures the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| map_sel | input | 1 | Static choice of control-bit positions (0 or 1) |
| gate_en | input | 1 | Allows chip-select gating of the ordinary outputs |
| d_in | input | 28 | Command/address inputs, bit n-1 = input n |
| q_a | output | 28 | Registered copy A |
| q_b | output | 28 | Registered copy B |

## Verification
The checker watches these rules on every clock: the two copies stay equal, the ordinary bits hold whenever the internal hold signal is asserted, everything loads when it is not, the control bits always follow their inputs, and the outputs are zero while reset is low. Those properties rely on the design's own control mask and hold decision. Only the bench's scenarios can show that these signals sit on the right input positions for each map setting. They compare against a model built independently from the position lists. The bench alone also shows that reset clears the outputs mid-cycle, and that the outputs stay zero between reset release and the first edge.

// File: rtl/csgdr_pkg.sv
package csgdr_pkg;

  localparam int LANE_W = 5;

  typedef enum logic {
    MAP_LOW  = 1'b0,
    MAP_HIGH = 1'b1
  } pin_map_e;

  // zero-based bit indexes of the six control lanes
  typedef struct packed {
    logic [LANE_W-1:0] cs0;
    logic [LANE_W-1:0] cs1;
    logic [LANE_W-1:0] cke0;
    logic [LANE_W-1:0] cke1;
    logic [LANE_W-1:0] odt0;
    logic [LANE_W-1:0] odt1;
  } lane_set_t;

  // R2 / R3: control-lane positions for each map (bit = input number - 1)
  function automatic lane_set_t lanes_for(pin_map_e m);
    lane_set_t l;
    if (m == MAP_HIGH) begin
      l.cs0  = LANE_W'(14);
      l.cs1  = LANE_W'(15);
      l.cke0 = LANE_W'(20);
      l.cke1 = LANE_W'(22);
      l.odt0 = LANE_W'(13);
      l.odt1 = LANE_W'(12);
    end else begin
      l.cs0  = LANE_W'(13);
      l.cs1  = LANE_W'(12);
      l.cke0 = LANE_W'(7);
      l.cke1 = LANE_W'(5);
      l.odt0 = LANE_W'(14);
      l.odt1 = LANE_W'(15);
    end
    return l;
  endfunction

  function automatic logic lane_hit(lane_set_t l, logic [LANE_W-1:0] idx);
    return (idx == l.cs0)  || (idx == l.cs1)  ||
           (idx == l.cke0) || (idx == l.cke1) ||
           (idx == l.odt0) || (idx == l.odt1);
  endfunction

  // R4 / R5: ordinary outputs freeze only when gating is on and no chip is selected
  function automatic logic freeze_rule(logic gate_en, logic cs0, logic cs1);
    return gate_en & cs0 & cs1;
  endfunction

endpackage

// File: rtl/csgdr_lane_map.sv
module csgdr_lane_map
  import csgdr_pkg::*;
#(
  parameter int NUM_BITS = 28
) (
  input  logic                map_sel,
  input  logic [NUM_BITS-1:0] d_in,
  output logic [NUM_BITS-1:0] ctrl_mask,
  output logic                cs0_val,
  output logic                cs1_val
);

  lane_set_t lanes;

  always_comb lanes = lanes_for(pin_map_e'(map_sel));

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_mask
    assign ctrl_mask[i] = lane_hit(lanes, LANE_W'(i));
  end

  assign cs0_val = d_in[lanes.cs0];
  assign cs1_val = d_in[lanes.cs1];

endmodule

// File: rtl/csgdr_gate_ctrl.sv
module csgdr_gate_ctrl
  import csgdr_pkg::*;
(
  input  logic gate_en,
  input  logic cs0_val,
  input  logic cs1_val,
  output logic hold
);

  assign hold = freeze_rule(gate_en, cs0_val, cs1_val);

endmodule

// File: rtl/csgdr_bit_reg.sv
module csgdr_bit_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q_a,
  output logic q_b
);

  // two separate flops, one per output copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_a <= 1'b0;
    end else if (load) begin
      q_a <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_b <= 1'b0;
    end else if (load) begin
      q_b <= d;
    end
  end

endmodule

// File: rtl/csgate_dup_reg.sv
module csgate_dup_reg #(
  parameter int NUM_BITS = 28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                map_sel,
  input  logic                gate_en,
  input  logic [NUM_BITS-1:0] d_in,
  output logic [NUM_BITS-1:0] q_a,
  output logic [NUM_BITS-1:0] q_b
);

  logic [NUM_BITS-1:0] ctrl_mask_w;
  logic                cs0_w;
  logic                cs1_w;
  logic                hold_w;
  logic [NUM_BITS-1:0] load_w;

  csgdr_lane_map #(.NUM_BITS(NUM_BITS)) u_map (
    .map_sel   (map_sel),
    .d_in      (d_in),
    .ctrl_mask (ctrl_mask_w),
    .cs0_val   (cs0_w),
    .cs1_val   (cs1_w)
  );

  csgdr_gate_ctrl u_gate (
    .gate_en (gate_en),
    .cs0_val (cs0_w),
    .cs1_val (cs1_w),
    .hold    (hold_w)
  );

  // control lanes always load; ordinary lanes load unless held
  assign load_w = ctrl_mask_w | {NUM_BITS{~hold_w}};

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    csgdr_bit_reg u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_w[i]),
      .d     (d_in[i]),
      .q_a   (q_a[i]),
      .q_b   (q_b[i])
    );
  end

endmodule

// File: rtl/csgdr_checker.sv
module csgdr_checker #(
  parameter int NUM_BITS = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_BITS-1:0] d_in,
  input logic [NUM_BITS-1:0] q_a,
  input logic [NUM_BITS-1:0] q_b,
  input logic                hold,
  input logic [NUM_BITS-1:0] ctrl_mask
);

  a_r1_copies_equal: assert property (@(posedge clk) disable iff (!rst_n)
    q_a == q_b);

  a_r4_ordinary_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ((q_a & ~$past(ctrl_mask)) == ($past(q_a) & ~$past(ctrl_mask))));

  a_r5_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (q_a == $past(d_in)));

  a_r6_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_a & $past(ctrl_mask)) == ($past(d_in) & $past(ctrl_mask))));

  a_r7_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (q_a == '0 && q_b == '0));

endmodule

bind csgate_dup_reg csgdr_checker #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .d_in      (d_in),
  .q_a       (q_a),
  .q_b       (q_b),
  .hold      (hold_w),
  .ctrl_mask (ctrl_mask_w)
);

// File: tb/tb_csgate_dup_reg.sv
module tb_csgate_dup_reg;

  localparam int N = 28;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         map_sel = 1'b0;
  logic         gate_en = 1'b0;
  logic [N-1:0] d_in = '0;
  logic [N-1:0] q_a;
  logic [N-1:0] q_b;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [N-1:0] model_q = '0;

  csgate_dup_reg #(.NUM_BITS(N)) dut (
    .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .gate_en(gate_en),
    .d_in(d_in), .q_a(q_a), .q_b(q_b)
  );

  always #2 clk = ~clk;

  // positions from the requirements, as input numbers
  function automatic logic [N-1:0] ctl_bits(logic m);
    logic [N-1:0] r = '0;
    int pos[6];
    if (m) pos = '{15, 16, 21, 23, 14, 13};
    else   pos = '{14, 13, 8, 6, 15, 16};
    foreach (pos[k]) r[pos[k]-1] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] with_cs(logic [N-1:0] v, logic m, logic c0, logic c1);
    logic [N-1:0] r = v;
    if (m) begin r[14] = c0; r[15] = c1; end
    else   begin r[13] = c0; r[12] = c1; end
    return r;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] d, logic ge, string req);
    logic [N-1:0] m;
    logic frz;
    @(negedge clk);
    d_in = d;
    gate_en = ge;
    m = ctl_bits(map_sel);
    frz = ge && (map_sel ? (d[14] && d[15]) : (d[13] && d[12]));
    model_q = frz ? ((model_q & ~m) | (d & m)) : d;
    @(posedge clk);
    #1;
    check(req, q_a, model_q);
    check({req, "/R1 copy B"}, q_b, model_q);
  endtask

  // R7 and R8: clear mid-cycle, release, first edge loads
  task automatic reset_and_release(logic m);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R7 async clear A", q_a, '0);
    check("R7 async clear B", q_b, '0);
    map_sel = m;
    model_q = '0;
    @(negedge clk);
    d_in = 28'h5A5_3C3C;
    gate_en = 1'b0;
    rst_n = 1'b1;
    #0.5;
    check("R8 low after release", q_a, '0);
    @(posedge clk);
    #1;
    model_q = d_in;
    check("R8 first edge loads", q_a, model_q);
  endtask

  task automatic open_load(logic m);
    step(with_cs(28'hFFF_FFFF, m, 1, 1), 1'b0, "R5 gate off, cs high");
    step(28'h0, 1'b0, "R5 all zero");
    for (int k = 0; k < 10; k++)
      step(N'($urandom), 1'b0, "R5 gate off random");
  endtask

  task automatic gated_hold(logic m);
    step(28'hABC_DEF1, 1'b0, "R5 preload");
    for (int k = 0; k < 12; k++)
      step(with_cs(N'($urandom), m, 1, 1), 1'b1,
           m ? "R3 R4 R6 gated hold" : "R2 R4 R6 gated hold");
  endtask

  task automatic one_cs_low(logic m);
    step(with_cs(N'($urandom), m, 0, 1), 1'b1, "R5 cs0 low");
    step(with_cs(N'($urandom), m, 1, 1), 1'b1, "R4 hold again");
    step(with_cs(N'($urandom), m, 1, 0), 1'b1, "R5 cs1 low");
    // other map's chip-select lanes high, this map's low: must load
    step(with_cs(with_cs(N'($urandom), ~m, 1, 1), m, 0, 0), 1'b1,
         m ? "R3 map lanes" : "R2 map lanes");
    for (int k = 0; k < 20; k++)
      step(N'($urandom), 1'b1, "R4 R5 R6 mixed random");
  endtask

  task automatic reset_while_gated(logic m);
    step(with_cs(28'h7FF_FFFF, m, 1, 1), 1'b1, "R4 setup");
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R7 priority over gating", q_a, '0);
    model_q = '0;
    @(posedge clk);
    #1;
    check("R7 held under reset", q_b, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #3;
    check("R7 reset state", q_a, '0);
    for (int m = 0; m < 2; m++) begin
      reset_and_release(m[0]);
      open_load(m[0]);
      gated_hold(m[0]);
      one_cs_low(m[0]);
      reset_while_gated(m[0]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule